// File: doc/BRIEF.md
# Multicast Configuration Bus

This block moves configuration words one way, from one configuration manager into the small configuration memories of four decoder processors. The manager sends bursts through a valid/ready port. The first beat of a burst carries a start entry and a beat count. Each later beat goes to the next entry up. A selector holds a target mask that the manager reloads at runtime with a separate strobe, or sets to all ones with a broadcast flag. Each word is written into every processor memory whose mask bit is set, so one burst can reach one memory, any subset of them, or all of them.

The path is a fixed-latency register pipeline with no back-pressure and no return path to the manager. Each processor reads its own memory through a private synchronous read port. A beat that would land beyond the last entry is dropped and reported on a one-cycle error pulse. So is a beat that is framed wrongly.

Top module: `cfg_mcast_bus`

## Requirements
- R1: While `rst` is high, `in_ready` and `err_o` are 0. Reset clears the target mask to all zeros and closes any open burst. Reset does not clear the memory contents.
- R2: A word accepted at clock edge k is written at edge k+5. Its value appears on the read port at edge k+6, because a read on the same edge as a write returns the old value.
- R3: A first beat (`in_first`=1) with `in_addr`=A and `in_len`=L opens a burst of L beats. Beat j of the burst, counting from 0, targets entry A+j.
- R4: A word is written into memory p exactly when bit p of the burst's mask is 1. Memories whose bit is 0 keep their contents.
- R5: On an edge with `sel_load`=1 and `sel_bcast`=1, the mask becomes all ones whatever `sel_mask` holds.
- R6: On an edge with `sel_load`=1 and `sel_bcast`=0, the mask is loaded from `sel_mask`. A burst uses the mask held when its first beat is accepted for all of its beats, even if the mask is reloaded mid-burst.
- R7: `in_ready` is 0 while `rst` is high and during any cycle with `sel_load`=1. Otherwise it is 1 from the first edge after reset is released.
- R8: A beat whose target entry is 12 or higher is dropped, and `err_o` is 1 for the one cycle after its acceptance edge. The burst still counts that beat.
- R9: A first beat with `in_len` of 0 or above 12 is dropped, opens no burst and pulses `err_o`. A non-first beat with no burst open is also dropped and pulses `err_o`.
- R10: A burst sent while the mask is all zeros is accepted without error and changes no memory.
- R11: A first beat accepted while a burst is still open abandons the open burst and starts the new one.
- R12: Lane p of `rd_data` shows entry `rd_addr` lane p of memory p one edge after the address is sampled, and shows 0 for an address of 12 or higher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Manager offers a beat |
| in_ready | output | 1 | Bus can take a beat this cycle |
| in_first | input | 1 | Beat opens a new burst |
| in_addr | input | 4 | Start entry (used on first beats) |
| in_len | input | 4 | Burst beat count (used on first beats) |
| in_data | input | 26 | Configuration word |
| sel_load | input | 1 | Load the target mask |
| sel_bcast | input | 1 | With `sel_load`, target all processors |
| sel_mask | input | 4 | Target mask, bit p selects processor p |
| err_o | output | 1 | One-cycle pulse for a dropped beat |
| rd_addr | input | 16 | Per-processor read entry, 4 bits per lane |
| rd_data | output | 104 | Per-processor read word, 26 bits per lane |

## Verification
Table-driven bursts cover a single target, a pair, alternating targets, three targets, a broadcast whose `sel_mask` bits are deliberately partial, a full twelve-beat burst and a one-beat burst at the top entry. After each burst, every entry of every memory is compared with a model. This exposes a wrong address step, a wrong lane decode, or a broadcast flag that does not override the mask. Directed cases then test:
- the exact write edge, with a read-before-write check;
- a mask reload in the middle of a burst;
- bursts that run off the end of the memory;
- bad lengths and stray beats;
- an all-zero mask;
- a burst restarted before it finishes.

A final reset in the middle of a burst shows that reset clears the mask and closes the open burst while the memory contents stay.

// File: rtl/cfg_mcast_pkg.sv
package cfg_mcast_pkg;
  // Framing state of the master interface
  typedef enum logic {
    BUS_IDLE  = 1'b0,
    BUS_BURST = 1'b1
  } burst_st_e;
endpackage

// File: rtl/cfg_mcast_master.sv
module cfg_mcast_master
  import cfg_mcast_pkg::*;
#(
  parameter int unsigned NP    = 4,
  parameter int unsigned DEPTH = 12,
  parameter int unsigned DW    = 26,
  parameter int unsigned AW    = 4,
  parameter int unsigned LW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_first,
  input  logic [AW-1:0] in_addr,
  input  logic [LW-1:0] in_len,
  input  logic [DW-1:0] in_data,
  input  logic          sel_load,
  input  logic [NP-1:0] cur_mask,
  output logic          s1_vld,
  output logic [AW-1:0] s1_addr,
  output logic [DW-1:0] s1_data,
  output logic [NP-1:0] s1_mask,
  output logic          err_o
);
  // One spare bit so that an address running past the top is visible
  localparam int unsigned XW = AW + 1;

  logic          ready_q;
  burst_st_e     st_q;
  logic [LW-1:0] rem_q;
  logic [XW-1:0] nxt_q;
  logic [NP-1:0] bmask_q;
  logic          err_q;

  logic          acc;
  logic          len_ok;
  logic          live;
  logic          wr;
  logic [XW-1:0] baddr;
  logic [NP-1:0] bmask;

  assign in_ready = ready_q & ~sel_load;
  assign acc      = in_valid & in_ready;
  assign len_ok   = (in_len != '0) && (in_len <= LW'(DEPTH));

  // Resolve the target of the beat offered this cycle
  always_comb begin
    live  = 1'b0;
    baddr = nxt_q;
    bmask = bmask_q;
    if (acc && in_first) begin
      live  = len_ok;
      baddr = {1'b0, in_addr};
      bmask = cur_mask;
    end else if (acc && (st_q == BUS_BURST)) begin
      live  = 1'b1;
    end
  end

  assign wr = live && (baddr < XW'(DEPTH));

  // Stage 1 of the write pipeline and the error pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      s1_vld  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      s1_vld  <= wr;
      err_q   <= acc & ~wr;
    end
  end

  always_ff @(posedge clk) begin
    s1_addr <= baddr[AW-1:0];
    s1_data <= in_data;
    s1_mask <= bmask;
  end

  // Burst framing: remaining beats, next entry, captured mask
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= BUS_IDLE;
      rem_q   <= '0;
      nxt_q   <= '0;
      bmask_q <= '0;
    end else if (acc) begin
      if (in_first) begin
        if (len_ok) begin
          st_q    <= (in_len > LW'(1)) ? BUS_BURST : BUS_IDLE;
          rem_q   <= in_len - LW'(1);
          nxt_q   <= {1'b0, in_addr} + XW'(1);
          bmask_q <= cur_mask;
        end else begin
          st_q    <= BUS_IDLE;
        end
      end else if (st_q == BUS_BURST) begin
        rem_q <= rem_q - LW'(1);
        nxt_q <= nxt_q + XW'(1);
        if (rem_q == LW'(1)) st_q <= BUS_IDLE;
      end
    end
  end

  assign err_o = err_q;

  // R3: a continuation beat moves the next entry up by exactly one
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && !in_first && (st_q == BUS_BURST)) |=> (nxt_q == $past(nxt_q) + XW'(1)));

  // R8: an error pulse always follows an accepted beat
  assert_err_follows_accept_R8: assert property (@(posedge clk) disable iff (rst)
    err_q |-> $past(acc));

  // R9: the last counted beat closes the burst
  assert_burst_close_R9: assert property (@(posedge clk) disable iff (rst)
    (acc && !in_first && (st_q == BUS_BURST) && (rem_q == LW'(1))) |=> (st_q == BUS_IDLE));
endmodule

// File: rtl/cfg_mcast_selector.sv
module cfg_mcast_selector #(
  parameter int unsigned NP   = 4,
  parameter int unsigned DW   = 26,
  parameter int unsigned AW   = 4,
  parameter int unsigned NSTG = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_load,
  input  logic          sel_bcast,
  input  logic [NP-1:0] sel_mask,
  output logic [NP-1:0] cur_mask,
  input  logic          s1_vld,
  input  logic [AW-1:0] s1_addr,
  input  logic [DW-1:0] s1_data,
  input  logic [NP-1:0] s1_mask,
  output logic [NP-1:0] tgt_we,
  output logic [AW-1:0] tgt_addr,
  output logic [DW-1:0] tgt_data
);
  logic [NP-1:0] mask_q;
  logic          vld_d  [NSTG];
  logic [AW-1:0] addr_d [NSTG];
  logic [DW-1:0] data_d [NSTG];
  logic [NP-1:0] msk_d  [NSTG];

  // Runtime target mask
  always_ff @(posedge clk) begin
    if (rst)           mask_q <= '0;
    else if (sel_load) mask_q <= sel_bcast ? '1 : sel_mask;
  end
  assign cur_mask = mask_q;

  // Delay line that sets the fixed transfer latency
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NSTG; k++) vld_d[k] <= 1'b0;
    end else begin
      vld_d[0] <= s1_vld;
      for (int k = 1; k < NSTG; k++) vld_d[k] <= vld_d[k-1];
    end
  end

  always_ff @(posedge clk) begin
    addr_d[0] <= s1_addr;
    data_d[0] <= s1_data;
    msk_d[0]  <= s1_mask;
    for (int k = 1; k < NSTG; k++) begin
      addr_d[k] <= addr_d[k-1];
      data_d[k] <= data_d[k-1];
      msk_d[k]  <= msk_d[k-1];
    end
  end

  // Fan-out decode, one enable per processor
  for (genvar p = 0; p < NP; p++) begin : g_dec
    assign tgt_we[p] = vld_d[NSTG-1] & msk_d[NSTG-1][p];
  end
  assign tgt_addr = addr_d[NSTG-1];
  assign tgt_data = data_d[NSTG-1];

  // R5: a broadcast load gives an all-ones mask
  assert_bcast_all_R5: assert property (@(posedge clk) disable iff (rst)
    (sel_load && sel_bcast) |=> (mask_q == '1));

  // R6: without a load strobe the mask holds
  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !sel_load |=> $stable(mask_q));
endmodule

// File: rtl/cfg_mcast_slave.sv
module cfg_mcast_slave #(
  parameter int unsigned DEPTH = 12,
  parameter int unsigned DW    = 26,
  parameter int unsigned AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_in,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  // Last pipeline stage, local to the memory
  always_ff @(posedge clk) begin
    if (rst) we_q <= 1'b0;
    else     we_q <= we_in;
  end

  always_ff @(posedge clk) begin
    addr_q <= addr_in;
    data_q <= data_in;
  end

  // Simple dual-port memory, read-before-write
  always_ff @(posedge clk) begin
    if (we_q) mem[addr_q] <= data_q;
    rd_q <= (rd_addr < AW'(DEPTH)) ? mem[rd_addr] : '0;
  end

  assign rd_data = rd_q;

  // R8: no write is ever aimed past the last entry
  assert_wr_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    we_q |-> (addr_q < AW'(DEPTH)));
endmodule

// File: rtl/cfg_mcast_bus.sv
module cfg_mcast_bus #(
  parameter int unsigned NP    = 4,
  parameter int unsigned DEPTH = 12,
  parameter int unsigned DW    = 26,
  parameter int unsigned LAT   = 5,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_first,
  input  logic [AW-1:0]    in_addr,
  input  logic [LW-1:0]    in_len,
  input  logic [DW-1:0]    in_data,
  input  logic             sel_load,
  input  logic             sel_bcast,
  input  logic [NP-1:0]    sel_mask,
  output logic             err_o,
  input  logic [NP*AW-1:0] rd_addr,
  output logic [NP*DW-1:0] rd_data
);
  // LAT counts master stage + delay line + slave stage; LAT must be 3 or more
  localparam int unsigned NSTG = LAT - 2;

  logic [NP-1:0] cur_mask;
  logic          s1_vld;
  logic [AW-1:0] s1_addr;
  logic [DW-1:0] s1_data;
  logic [NP-1:0] s1_mask;
  logic [NP-1:0] tgt_we;
  logic [AW-1:0] tgt_addr;
  logic [DW-1:0] tgt_data;

  cfg_mcast_master #(
    .NP(NP), .DEPTH(DEPTH), .DW(DW), .AW(AW), .LW(LW)
  ) u_master (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_first (in_first),
    .in_addr  (in_addr),
    .in_len   (in_len),
    .in_data  (in_data),
    .sel_load (sel_load),
    .cur_mask (cur_mask),
    .s1_vld   (s1_vld),
    .s1_addr  (s1_addr),
    .s1_data  (s1_data),
    .s1_mask  (s1_mask),
    .err_o    (err_o)
  );

  cfg_mcast_selector #(
    .NP(NP), .DW(DW), .AW(AW), .NSTG(NSTG)
  ) u_sel (
    .clk       (clk),
    .rst       (rst),
    .sel_load  (sel_load),
    .sel_bcast (sel_bcast),
    .sel_mask  (sel_mask),
    .cur_mask  (cur_mask),
    .s1_vld    (s1_vld),
    .s1_addr   (s1_addr),
    .s1_data   (s1_data),
    .s1_mask   (s1_mask),
    .tgt_we    (tgt_we),
    .tgt_addr  (tgt_addr),
    .tgt_data  (tgt_data)
  );

  for (genvar p = 0; p < NP; p++) begin : g_slv
    cfg_mcast_slave #(
      .DEPTH(DEPTH), .DW(DW), .AW(AW)
    ) u_slv (
      .clk     (clk),
      .rst     (rst),
      .we_in   (tgt_we[p]),
      .addr_in (tgt_addr),
      .data_in (tgt_data),
      .rd_addr (rd_addr[p*AW +: AW]),
      .rd_data (rd_data[p*DW +: DW])
    );
  end
endmodule

// File: tb/cfg_mcast_bus_tb.sv
`timescale 1ns/1ps
module cfg_mcast_bus_tb;
  localparam int NP = 4, DEPTH = 12, DW = 26, AW = 4, LW = 4, LAT = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_first = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [LW-1:0] in_len = '0;
  logic [DW-1:0] in_data = '0;
  logic sel_load = 1'b0, sel_bcast = 1'b0;
  logic [NP-1:0] sel_mask = '0;
  logic in_ready, err_o;
  logic [NP*AW-1:0] rd_addr = '0;
  logic [NP*DW-1:0] rd_data;

  int checks = 0, failures = 0;
  logic [DW-1:0] model [NP][DEPTH];

  always #2 clk = ~clk;

  cfg_mcast_bus #(.NP(NP), .DEPTH(DEPTH), .DW(DW), .LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_addr(in_addr), .in_len(in_len), .in_data(in_data),
    .sel_load(sel_load), .sel_bcast(sel_bcast), .sel_mask(sel_mask),
    .err_o(err_o), .rd_addr(rd_addr), .rd_data(rd_data));

  // vector: {mask[3:0], bcast, addr[3:0], len[3:0], seed[7:0]}
  localparam logic [20:0] VTAB [6] = '{
    {4'b0001, 1'b0, 4'd0,  4'd12, 8'h21},
    {4'b0110, 1'b0, 4'd3,  4'd4,  8'h32},
    {4'b1010, 1'b0, 4'd7,  4'd5,  8'h43},
    {4'b0100, 1'b1, 4'd1,  4'd2,  8'h54},
    {4'b1000, 1'b0, 4'd11, 4'd1,  8'h65},
    {4'b1101, 1'b0, 4'd5,  4'd3,  8'h76}
  };

  function automatic logic [DW-1:0] mk(input logic [7:0] seed, input int j);
    logic [17:0] lo;
    lo = 18'(j * 2731 + int'(seed) * 7 + 5);
    return {seed, lo};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic model_burst(input logic [3:0] m, input int a, input int l, input logic [7:0] seed);
    for (int j = 0; j < l; j++)
      if (a + j < DEPTH)
        for (int p = 0; p < NP; p++)
          if (m[p]) model[p][a+j] = mk(seed, j);
  endtask

  task automatic load_sel(input logic b, input logic [3:0] m);
    sel_load = 1'b1; sel_bcast = b; sel_mask = m;
    @(posedge clk); #1;
    sel_load = 1'b0; sel_bcast = 1'b0;
  endtask

  // Drive one beat, accepted at the next edge; returns err_o sampled after it
  task automatic beat(input logic f, input logic [3:0] a, input logic [3:0] l,
                      input logic [DW-1:0] d, output logic e);
    in_valid = 1'b1; in_first = f; in_addr = a; in_len = l; in_data = d;
    @(posedge clk); #1;
    in_valid = 1'b0; in_first = 1'b0;
    e = err_o;
  endtask

  task automatic burst(input int a, input int l, input logic [7:0] seed, output int nerr);
    logic e;
    nerr = 0;
    for (int j = 0; j < l; j++) begin
      beat(j == 0, 4'(a), 4'(l), mk(seed, j), e);
      if (e) nerr++;
    end
  endtask

  task automatic drain();
    repeat (LAT + 2) @(posedge clk);
    #1;
  endtask

  task automatic check_mems(input string tag);
    for (int e = 0; e < DEPTH; e++) begin
      rd_addr = {NP{4'(e)}};
      @(posedge clk); #1;
      for (int p = 0; p < NP; p++)
        chk($sformatf("%s mem%0d[%0d]", tag, p, e), 32'(rd_data[p*DW +: DW]), 32'(model[p][e]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int nerr;
    logic e;
    // R1/R7: reset state
    repeat (3) @(posedge clk); #1;
    chk("R1 in_ready in reset", 32'(in_ready), 0);
    chk("R1 err_o in reset", 32'(err_o), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R7 in_ready after reset", 32'(in_ready), 1);

    // R5: broadcast load then full fill of every memory
    load_sel(1'b1, 4'b0000);
    burst(0, 12, 8'h11, nerr);
    model_burst(4'hF, 0, 12, 8'h11);
    chk("R5 init errors", 32'(nerr), 0);
    drain();
    check_mems("R5 init");

    // R3/R4/R5: table of bursts
    for (int v = 0; v < 6; v++) begin
      logic [20:0] ent;
      logic [3:0] em;
      ent = VTAB[v];
      load_sel(ent[16], ent[20:17]);
      em = ent[16] ? 4'hF : ent[20:17];
      burst(int'(ent[15:12]), int'(ent[11:8]), ent[7:0], nerr);
      model_burst(em, int'(ent[15:12]), int'(ent[11:8]), ent[7:0]);
      chk($sformatf("R3 vec%0d errors", v), 32'(nerr), 0);
      drain();
      check_mems($sformatf("R4 vec%0d", v));
    end

    // R2: exact write edge, seen on the read port
    load_sel(1'b0, 4'b0100);
    rd_addr = {NP{4'd5}};
    beat(1'b1, 4'd5, 4'd1, 26'h2ABCDEF, e);
    chk("R2 no error", 32'(e), 0);
    repeat (4) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    chk("R2 old value at k+5", 32'(rd_data[2*DW +: DW]), 32'(model[2][5]));
    @(posedge clk); #1;
    chk("R2 new value at k+6", 32'(rd_data[2*DW +: DW]), 32'h2ABCDEF);
    chk("R4 lane1 untouched", 32'(rd_data[1*DW +: DW]), 32'(model[1][5]));
    model[2][5] = 26'h2ABCDEF;

    // R7: ready low during a mask load
    sel_load = 1'b1; sel_mask = 4'b0001; #1;
    chk("R7 ready low on load", 32'(in_ready), 0);
    @(posedge clk); #1; sel_load = 1'b0; #1;
    chk("R7 ready back high", 32'(in_ready), 1);

    // R6: reload in mid-burst leaves the burst mask alone
    beat(1'b1, 4'd4, 4'd3, mk(8'h88, 0), e);
    load_sel(1'b0, 4'b0010);
    beat(1'b0, 4'd0, 4'd0, mk(8'h88, 1), e);
    beat(1'b0, 4'd0, 4'd0, mk(8'h88, 2), e);
    model_burst(4'b0001, 4, 3, 8'h88);
    burst(0, 1, 8'h99, nerr);
    model_burst(4'b0010, 0, 1, 8'h99);
    drain();
    check_mems("R6 mid-burst reload");

    // R8: burst running off the top
    load_sel(1'b0, 4'b1111);
    burst(10, 4, 8'hA1, nerr);
    model_burst(4'hF, 10, 4, 8'hA1);
    chk("R8 dropped beats flagged", 32'(nerr), 2);
    @(posedge clk); #1;
    chk("R8 error is one cycle", 32'(err_o), 0);
    // R9: that burst is closed, a stray beat errors
    beat(1'b0, 4'd0, 4'd0, 26'h1, e);
    chk("R9 stray after overrun", 32'(e), 1);
    beat(1'b1, 4'd0, 4'd0, 26'h2, e);
    chk("R9 length zero", 32'(e), 1);
    beat(1'b1, 4'd0, 4'd13, 26'h3, e);
    chk("R9 length 13", 32'(e), 1);
    beat(1'b0, 4'd0, 4'd0, 26'h4, e);
    chk("R9 no burst after bad length", 32'(e), 1);
    drain();
    check_mems("R8 R9 memories");

    // R10: all-zero mask
    load_sel(1'b0, 4'b0000);
    burst(0, 3, 8'hB2, nerr);
    chk("R10 no error", 32'(nerr), 0);
    drain();
    check_mems("R10 zero mask");

    // R11: restart an open burst
    load_sel(1'b0, 4'b0001);
    beat(1'b1, 4'd2, 4'd4, 26'h0C0FFEE, e);
    beat(1'b0, 4'd0, 4'd0, 26'h0BEEF01, e);
    beat(1'b1, 4'd8, 4'd2, 26'h1234567, e);
    chk("R11 restart no error", 32'(e), 0);
    beat(1'b0, 4'd0, 4'd0, 26'h0765432, e);
    beat(1'b0, 4'd0, 4'd0, 26'h3FFFFFF, e);
    chk("R11 old burst abandoned", 32'(e), 1);
    model[0][2] = 26'h0C0FFEE; model[0][3] = 26'h0BEEF01;
    model[0][8] = 26'h1234567; model[0][9] = 26'h0765432;
    drain();
    check_mems("R11 restart");

    // R12: read beyond the last entry
    rd_addr = {NP{4'd13}};
    @(posedge clk); #1;
    chk("R12 out-of-range read", 32'(rd_data[0 +: DW]), 0);

    // R1: reset mid-burst clears mask and framing, keeps memory
    load_sel(1'b0, 4'b1111);
    beat(1'b1, 4'd0, 4'd4, 26'h1111111, e);
    model[0][0] = 26'h1111111; model[1][0] = 26'h1111111;
    model[2][0] = 26'h1111111; model[3][0] = 26'h1111111;
    drain();
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 ready in reset", 32'(in_ready), 0);
    chk("R1 err in reset", 32'(err_o), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    beat(1'b0, 4'd0, 4'd0, 26'h5, e);
    chk("R1 burst closed by reset", 32'(e), 1);
    burst(0, 12, 8'hC3, nerr);
    chk("R1 zero mask no error", 32'(nerr), 0);
    drain();
    check_mems("R1 mask cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule